// File: doc/BRIEF.md
# Optical-Black Recursive Black Clamp

This block sits in a raw sensor pixel path and removes the sensor's black offset from every active pixel. Each incoming line begins with a run of shielded reference pixels whose values show the dark level. The block sums a fixed count of 48 such pixels per line and divides the sum into a rounded average. It then folds that average into a running black estimate through a first-order recursive filter. The filter weight is programmable, so line-to-line noise in the reference pixels does not show up as horizontal banding.

Each accepted pixel comes with its own row and column index. Those indices are compared against programmable windows: one reference window of 48 columns, and a rectangle of effective columns and rows. Pixels inside the effective rectangle leave the block one cycle later with the estimate subtracted and the result floored at zero. No other pixel produces an output. The weight and every window edge can be changed through a small write-only configuration port. The first reference window completed after reset loads the estimate directly, without blending.

Top module: `obc_black_clamp`

## Requirements
- R1: After reset, `out_valid` is 0 and the black estimate is 0, so an effective pixel seen before any reference window completes leaves the block unchanged.
- R2: The line average is floor((S + 24) / 48), where S is the sum of the 48 accepted pixels in columns ob_start to ob_start+47.
- R3: The first reference window completed after reset sets the estimate equal to that window's average.
- R4: Every later window with weight k (0..15) updates the estimate to E + floor(((A − E)·(16 − k) + 8) / 16), where E is the old estimate and A is the new average.
- R5: A new estimate applies from the accepted pixel that follows the window's last column, on the same line. Until then, the old estimate applies.
- R6: For an effective pixel P, `out_pix` is P − E, or 0 when E > P. It is valid on the clock edge after the pixel is presented.
- R7: `out_valid` is 1 only for accepted pixels with c0 ≤ column ≤ c1 and r0 ≤ row ≤ r1. Reference, trailing and out-of-window pixels produce none.
- R8: A pixel is accepted only when `line_valid` and `frame_valid` are both 1. Other pixels neither produce output nor change the running sum or the estimate.
- R9: The configuration write port decodes these addresses: 0 is k (bits 3:0), 1 is ob_start, 2 is c0, 3 is c1, 4 is r0 and 5 is r1. Writes to addresses 6 and 7 have no effect. The reset values are k=8, ob_start=0, c0=48, c1=2887, r0=8 and r1=2135.
- R10: With k=0 the estimate becomes the new average exactly. With k=15 it moves by one sixteenth of the rounded difference.
- R11: Moving ob_start moves the averaged columns to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 12 | Configuration write data |
| frame_valid | input | 1 | Frame qualifier |
| line_valid | input | 1 | Line qualifier |
| row_idx | input | 12 | Row of the current pixel |
| col_idx | input | 12 | Column of the current pixel |
| pix_in | input | 12 | Unsigned pixel sample |
| out_valid | output | 1 | Corrected pixel valid |
| out_pix | output | 12 | Corrected pixel value |

## Verification
Each corrected pixel is due on the rising edge after its input is presented. The bench drives every pixel at a falling edge and compares the outputs 1 ns after the next rising edge, so every expectation is tied to one specific pixel. A new estimate must be visible on the very next accepted pixel after a window's last column. The bench model therefore updates its estimate right after checking that last reference pixel, and the next check already uses the new value. Configuration writes take effect at their write edge, and the model follows them at the same point.

// File: rtl/obc_pkg.sv
`timescale 1ns/1ps
package obc_pkg;
    localparam int PIX_W  = 12;
    localparam int POS_W  = 12;
    localparam int K_W    = 4;
    localparam int CFG_AW = 3;

    localparam logic [CFG_AW-1:0] ADDR_K   = 3'd0;
    localparam logic [CFG_AW-1:0] ADDR_OB0 = 3'd1;
    localparam logic [CFG_AW-1:0] ADDR_C0  = 3'd2;
    localparam logic [CFG_AW-1:0] ADDR_C1  = 3'd3;
    localparam logic [CFG_AW-1:0] ADDR_R0  = 3'd4;
    localparam logic [CFG_AW-1:0] ADDR_R1  = 3'd5;

    typedef struct packed {
        logic [K_W-1:0]   k;
        logic [POS_W-1:0] ob0;
        logic [POS_W-1:0] c0;
        logic [POS_W-1:0] c1;
        logic [POS_W-1:0] r0;
        logic [POS_W-1:0] r1;
    } cfg_t;
endpackage

// File: rtl/obc_cfg_regs.sv
`timescale 1ns/1ps
module obc_cfg_regs
    import obc_pkg::*;
#(
    parameter int DEF_K   = 8,
    parameter int DEF_OB0 = 0,
    parameter int DEF_C0  = 48,
    parameter int DEF_C1  = 2887,
    parameter int DEF_R0  = 8,
    parameter int DEF_R1  = 2135
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CFG_AW-1:0] addr,
    input  logic [POS_W-1:0]  wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            unique case (addr)
                ADDR_K:   cfg_d.k   = wdata[K_W-1:0];
                ADDR_OB0: cfg_d.ob0 = wdata;
                ADDR_C0:  cfg_d.c0  = wdata;
                ADDR_C1:  cfg_d.c1  = wdata;
                ADDR_R0:  cfg_d.r0  = wdata;
                ADDR_R1:  cfg_d.r1  = wdata;
                default:  cfg_d     = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.k   <= K_W'(DEF_K);
            cfg_q.ob0 <= POS_W'(DEF_OB0);
            cfg_q.c0  <= POS_W'(DEF_C0);
            cfg_q.c1  <= POS_W'(DEF_C1);
            cfg_q.r0  <= POS_W'(DEF_R0);
            cfg_q.r1  <= POS_W'(DEF_R1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R9
    cfg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr > ADDR_R1) |=> $stable(cfg_q));
endmodule

// File: rtl/obc_ob_accum.sv
`timescale 1ns/1ps
module obc_ob_accum
    import obc_pkg::*;
#(
    parameter int OB_PIX = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [POS_W-1:0] col,
    input  logic [PIX_W-1:0] pix,
    input  logic [POS_W-1:0] ob0,
    output logic             avg_valid,
    output logic [PIX_W-1:0] avg
);
    localparam int SUM_W = PIX_W + $clog2(OB_PIX) + 1;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [POS_W:0]   col_x, ob_end;
    logic             in_win, first, last;
    logic [SUM_W-1:0] sum_fin;

    always_comb begin
        col_x   = {1'b0, col};
        ob_end  = {1'b0, ob0} + (POS_W+1)'(OB_PIX);
        in_win  = acc && (col >= ob0) && (col_x < ob_end);
        first   = acc && (col == ob0);
        last    = acc && (col_x == ob_end - (POS_W+1)'(1));
        sum_fin = (first ? '0 : st_q.sum) + {{(SUM_W-PIX_W){1'b0}}, pix};
        st_d    = st_q;
        if (in_win) st_d.sum = sum_fin;
        avg_valid = last;
        avg = PIX_W'((sum_fin + SUM_W'(OB_PIX / 2)) / SUM_W'(OB_PIX));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    sum_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !first) |=> (st_q.sum >= $past(st_q.sum)));
endmodule

// File: rtl/obc_blend.sv
`timescale 1ns/1ps
module obc_blend
    import obc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             avg_valid,
    input  logic [PIX_W-1:0] avg,
    input  logic [K_W-1:0]   k,
    output logic [PIX_W-1:0] est
);
    localparam int PROD_W = PIX_W + K_W + 3;
    localparam logic [K_W:0] ONE_K = (K_W+1)'(2**K_W);
    localparam logic signed [PROD_W-1:0] RND = PROD_W'(2**(K_W-1));

    typedef struct packed {
        logic [PIX_W-1:0] est;
        logic             primed;
    } bl_st_t;

    bl_st_t st_d, st_q;
    logic signed [PROD_W-1:0] est_x, diff_s, wgt_s, prod_s, rnd_s, step_s;
    logic        [K_W:0]      wgt_u;

    always_comb begin
        est_x  = $signed({{(PROD_W-PIX_W){1'b0}}, st_q.est});
        diff_s = $signed({{(PROD_W-PIX_W){1'b0}}, avg}) - est_x;
        wgt_u  = ONE_K - {1'b0, k};
        wgt_s  = $signed({{(PROD_W-K_W-1){1'b0}}, wgt_u});
        prod_s = diff_s * wgt_s;
        rnd_s  = prod_s + RND;
        step_s = rnd_s >>> K_W;
        st_d   = st_q;
        if (avg_valid) begin
            st_d.primed = 1'b1;
            if (!st_q.primed) st_d.est = avg;
            else              st_d.est = PIX_W'(est_x + step_s);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign est = st_q.est;

    // R3
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_valid && !st_q.primed) |=> (st_q.est == $past(avg)));
    // R5
    est_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_valid |=> $stable(st_q.est));
    // R4
    blend_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_valid && st_q.primed) |=>
        (((st_q.est >= $past(st_q.est)) && (st_q.est <= $past(avg))) ||
         ((st_q.est <= $past(st_q.est)) && (st_q.est >= $past(avg)))));
endmodule

// File: rtl/obc_clamp_out.sv
`timescale 1ns/1ps
module obc_clamp_out
    import obc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [POS_W-1:0] row,
    input  logic [POS_W-1:0] col,
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] est,
    input  logic [POS_W-1:0] c0,
    input  logic [POS_W-1:0] c1,
    input  logic [POS_W-1:0] r0,
    input  logic [POS_W-1:0] r1,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
    } out_st_t;

    out_st_t st_d, st_q;
    logic         in_act;
    logic [PIX_W:0] diff;

    always_comb begin
        in_act = acc && (col >= c0) && (col <= c1) && (row >= r0) && (row <= r1);
        diff   = {1'b0, pix} - {1'b0, est};
        st_d.vld = in_act;
        st_d.pix = st_q.pix;
        if (in_act) st_d.pix = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_pix   = st_q.pix;

    // R6
    out_le_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.pix <= $past(pix)));
    // R8
    out_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(acc));
endmodule

// File: rtl/obc_black_clamp.sv
`timescale 1ns/1ps
module obc_black_clamp
    import obc_pkg::*;
#(
    parameter int OB_PIX    = 48,
    parameter int ACT_PIX   = 2840,
    parameter int OB_LINES  = 8,
    parameter int ACT_LINES = 2128,
    parameter int DEF_K     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [POS_W-1:0]  cfg_wdata,
    input  logic              frame_valid,
    input  logic              line_valid,
    input  logic [POS_W-1:0]  row_idx,
    input  logic [POS_W-1:0]  col_idx,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int DEF_C0 = OB_PIX;
    localparam int DEF_C1 = OB_PIX + ACT_PIX - 1;
    localparam int DEF_R0 = OB_LINES;
    localparam int DEF_R1 = OB_LINES + ACT_LINES - 1;

    cfg_t             cfg;
    logic             acc;
    logic             avg_valid;
    logic [PIX_W-1:0] avg, est;

    assign acc = line_valid && frame_valid;

    obc_cfg_regs #(
        .DEF_K(DEF_K), .DEF_OB0(0), .DEF_C0(DEF_C0), .DEF_C1(DEF_C1),
        .DEF_R0(DEF_R0), .DEF_R1(DEF_R1)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    obc_ob_accum #(.OB_PIX(OB_PIX)) accum_i (
        .clk(clk), .rst_n(rst_n), .acc(acc), .col(col_idx), .pix(pix_in),
        .ob0(cfg.ob0), .avg_valid(avg_valid), .avg(avg)
    );

    obc_blend blend_i (
        .clk(clk), .rst_n(rst_n), .avg_valid(avg_valid), .avg(avg),
        .k(cfg.k), .est(est)
    );

    obc_clamp_out clamp_i (
        .clk(clk), .rst_n(rst_n), .acc(acc), .row(row_idx), .col(col_idx),
        .pix(pix_in), .est(est), .c0(cfg.c0), .c1(cfg.c1), .r0(cfg.r0),
        .r1(cfg.r1), .out_valid(out_valid), .out_pix(out_pix)
    );
endmodule

// File: tb/obc_black_clamp_tb.sv
`timescale 1ns/1ps
module obc_black_clamp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        frame_valid = 1'b0, line_valid = 1'b0;
    logic [11:0] row_idx = '0, col_idx = '0, pix_in = '0;
    logic        out_valid;
    logic [11:0] out_pix;

    int errors = 0, checks = 0;
    bit done = 0;

    int est_m = 0, primed_m = 0, sum_m = 0;
    int k_m = 8, ob0_m = 0, c0_m = 48, c1_m = 2887, r0_m = 8, r1_m = 2135;

    // row, k, ob_base, ob_ramp, act_base
    localparam int VEC [8][5] = '{
        '{0, 8, 200, 1, 300},
        '{1, 8, 240, 3, 250},
        '{2, 4, 100, 2, 500},
        '{3, 0, 900, 5, 1000},
        '{4, 15, 50, 0, 1200},
        '{5, 12, 3000, 7, 100},
        '{6, 8, 4095, 0, 4000},
        '{7, 2, 0, 0, 20}
    };

    always #2.5 clk = ~clk;

    obc_black_clamp dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_valid(frame_valid), .line_valid(line_valid),
        .row_idx(row_idx), .col_idx(col_idx), .pix_in(pix_in),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 12'(data);
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        case (addr)
            0: k_m = data % 16;
            1: ob0_m = data;
            2: c0_m = data;
            3: c1_m = data;
            4: r0_m = data;
            5: r1_m = data;
            default: ;
        endcase
    endtask

    task automatic pix(input int row, input int col, input int val,
                       input bit lv, input bit fv, input string tag);
        bit acc, exp_v;
        int exp_d, avg, p;
        acc = lv && fv;
        exp_v = acc && col >= c0_m && col <= c1_m && row >= r0_m && row <= r1_m;
        exp_d = (val > est_m) ? val - est_m : 0;
        @(negedge clk);
        line_valid = lv; frame_valid = fv;
        row_idx = 12'(row); col_idx = 12'(col); pix_in = 12'(val);
        @(posedge clk); #1;
        line_valid = 1'b0; frame_valid = 1'b0;
        checks++;
        if (out_valid !== exp_v || (exp_v && out_pix !== 12'(exp_d))) begin
            errors++;
            $display("FAIL %s row=%0d col=%0d: actual valid=%0b data=%0d expected valid=%0b data=%0d",
                     tag, row, col, out_valid, out_pix, exp_v, exp_d);
        end
        if (acc && col >= ob0_m && col < ob0_m + 48) begin
            if (col == ob0_m) sum_m = val; else sum_m += val;
            if (col == ob0_m + 47) begin
                avg = (sum_m + 24) / 48;
                if (!primed_m) begin est_m = avg; primed_m = 1; end
                else begin
                    p = (avg - est_m) * (16 - k_m) + 8;
                    est_m = est_m + (p >>> 4);
                end
            end
        end
    endtask

    task automatic line(input int row, input int ob_base, input int ob_ramp,
                        input int act_base, input string tag);
        for (int c = 0; c < 60; c++) begin
            int v;
            if (c >= ob0_m && c < ob0_m + 48) v = ob_base + (c % 4) * ob_ramp;
            else v = act_base + c;
            if (v > 4095) v = 4095;
            pix(row, c, v, 1'b1, 1'b1, tag);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual valid=%0b expected valid=0", out_valid);
        end
        // R1 R9: estimate zero and default windows before any programming
        pix(8, 48, 777, 1, 1, "R1");
        pix(7, 100, 500, 1, 1, "R9");
        pix(8, 2888, 600, 1, 1, "R9");
        pix(8, 2887, 50, 1, 1, "R9");
        // R3 first load, then default k=8 blend (R9)
        line(8, 400, 2, 900, "R3");
        line(9, 800, 1, 1500, "R9");
        // narrow windows for the table walk
        cfg_write(2, 48); cfg_write(3, 57);
        cfg_write(4, 1);  cfg_write(5, 100);
        // R2 R4 R6 R7 R10: vector table walk
        for (int i = 0; i < 8; i++) begin
            cfg_write(0, VEC[i][1]);
            line(VEC[i][0], VEC[i][2], VEC[i][3], VEC[i][4], "R4");
        end
        // R9: writes to unused addresses are ignored
        cfg_write(6, 15); cfg_write(7, 0);
        line(10, 1000, 3, 2000, "R9");
        // R8: gaps with line_valid low carry garbage
        for (int c = 0; c < 60; c++) begin
            pix(13, c, 4095, 1'b0, 1'b1, "R8");
            pix(13, c, (c < 48) ? 600 + c : 3000 + c, 1'b1, 1'b1, "R8");
        end
        // R8: a whole line with frame_valid low
        for (int c = 0; c < 60; c++) pix(14, c, 4000, 1'b1, 1'b0, "R8");
        line(15, 610, 0, 700, "R8");
        // R11: moved reference window and active columns
        cfg_write(1, 4); cfg_write(2, 52); cfg_write(3, 59);
        cfg_write(0, 5);
        line(16, 2500, 4, 3500, "R11");
        line(17, 30, 1, 2600, "R11");
        // R5 R10: k=0 makes the line's own average apply at once
        cfg_write(0, 0);
        line(18, 1234, 0, 1300, "R5");
        done = 1;
        summary();
        $finish;
    end
endmodule